// File: doc/BRIEF.md
# Component Register Bank with Decoder Commit

This block is the 32-bit memory-mapped register bank of a memory-expansion component. It holds a set of capability header words, the RAS error status, mask and severity registers, a decoder capability and global control word, and the programming registers of a parameterised number of host-managed memory decoders. A plain bus with a word address, an access size in bytes, write data and separate read and write strobes reaches it. Every register carries a write mask: bits outside the mask keep their value through any write.

Writing the control word of a decoder runs a commit handshake. The commit request bit that software writes drives a committed flag, and the error flag is cleared on every such write. A component-type parameter fixes which capabilities exist, their reset values and their write masks. A capability that is absent for the chosen type reads as zero and ignores writes.

Word layout (word addresses): 0x00 main header, 0x01 RAS header, 0x02 link header, 0x03 decoder header, 0x04 extended-security header, 0x05 snoop header; 0x08 uncorrectable status, 0x09 uncorrectable mask, 0x0A uncorrectable severity, 0x0B correctable status, 0x0C correctable mask, 0x0D RAS control; 0x10 decoder capability, 0x11 decoder global control; decoder n occupies 0x18 + 8n + k, where k = 0 base low, 1 base high, 2 size low, 3 size high, 4 control, 5 target list low, 6 target list high.

Top module: `comp_regfile`

## Requirements
- R1: Only an access with size 4 reaches the registers. A read with size 8 (or any size other than 4) returns 0, and a write with such a size changes no register.
- R2: A word write stores (wdata AND mask) OR (old AND NOT mask). Bits outside the mask, and every bit of a header word (mask 0), keep their value.
- R3: A write to a decoder control word with bit 9 (commit request) at 1 sets bit 10 (committed) to 1 and bit 11 (error) to 0. The control mask is 0x13FF.
- R4: A write to a decoder control word with bit 9 at 0 clears bit 10 and bit 11.
- R5: Decoder base and size words are stored through the mask with no commit side effect: low-word masks 0xF0000000, high-word masks 0xFFFFFFFF, reset value 0.
- R6: The uncorrectable status, mask and severity words use mask 0x1CFFF. The mask and severity words reset to 0x1CFFF, and the status word resets to 0.
- R7: The correctable status and mask words use mask 0x7F. The mask word resets to 0x7F and the status word to 0. The RAS control word resets to 0x200 and is read-only.
- R8: The decoder global control word has mask 0x3 and resets to 0. The decoder capability word reads {target count 1 in bits 7:4, bits 8 and 9 set, encoded decoder count in bits 3:0}, which is 0x312 for four decoders.
- R9: The target-list-low mask is 0xF0000000 for device types and 0xFFFFFFFF for port and bridge types. The target-list-high mask is 0xFFFFFFFF.
- R10: Main header = {array size[31:24], 4'h1, 4'h1, 16'h0001}. The array size is 2 for downstream ports and plain devices, 3 for upstream ports and memory devices, and 5 for root ports and root complexes. Sub-headers read {pointer[31:20], 4'h1, id[15:0]}: RAS id 2 with pointer 0x020, link id 4, decoder id 5 with pointer 0x040, extended security id 6, snoop id 8. A root port has no decoder header and no decoder registers, and both read 0.
- R11: Read data is registered. It shows the addressed word one cycle after the read strobe and holds when there is no read. Unmapped words read 0. A read and a write to the same word in the same cycle return the value before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
A read and a write can strike the same word in the same cycle. This matters most on a decoder control word, where the write also rewrites the committed and error flags. The bench raises both strobes together on one address and expects the value from before the write. A plain read on the next access must then show the merged value, so a read path that forwards the incoming data, or a write that lands one cycle late, shows up in one of the two reads.

// File: rtl/comp_regfile_pkg.sv
// Package: component types and the static tables derived from them.
// Assumes: callers pass a legal component type; decoder count is one of the encodable values.
package comp_regfile_pkg;

    typedef enum logic [2:0] {
        CT_DSP,   // downstream port
        CT_DEV,   // plain device
        CT_USP,   // upstream port
        CT_MEM,   // memory device
        CT_LD,    // logical device
        CT_RP,    // root port
        CT_RC     // root complex
    } comp_type_e;

    localparam int CR_STRIDE   = 8;     // words per decoder
    localparam int CR_DEC_BASE = 24;    // word address of decoder 0
    localparam int CR_DEC_WORDS = 7;    // used words per decoder
    localparam int CR_CTRL_IDX = 4;     // control word inside a decoder

    function automatic int caps_of(comp_type_e t);
        case (t)
            CT_DSP, CT_DEV:         return 2;
            CT_USP, CT_MEM, CT_LD:  return 3;
            default:                return 5;
        endcase
    endfunction

    function automatic bit has_ras(comp_type_e t);
        return t != CT_RC;
    endfunction

    function automatic bit has_dec(comp_type_e t);
        return (caps_of(t) >= 3) && (t != CT_RP);
    endfunction

    function automatic bit is_device(comp_type_e t);
        return (t == CT_DEV) || (t == CT_MEM) || (t == CT_LD);
    endfunction

    function automatic logic [3:0] dec_count_enc(int n);
        case (n)
            1: return 4'h0;   2: return 4'h1;   4: return 4'h2;
            6: return 4'h3;   8: return 4'h4;  10: return 4'h5;
            12: return 4'h6; 14: return 4'h7;  16: return 4'h8;
            20: return 4'h9; 24: return 4'ha;  28: return 4'hb;
            32: return 4'hc;
            default: return 4'h0;
        endcase
    endfunction

    // Write mask of word k inside one decoder.
    function automatic logic [31:0] dec_word_mask(int k, bit dev);
        case (k)
            0, 2:    return 32'hF000_0000;
            1, 3, 6: return 32'hFFFF_FFFF;
            4:       return 32'h0000_13FF;
            5:       return dev ? 32'hF000_0000 : 32'hFFFF_FFFF;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/cr_word.sv
// Module: one 32-bit register with a write mask and an optional commit handshake.
// Assumes: we is already qualified to a legal word write for this register.
module cr_word #(
    parameter logic [31:0] RST_VAL = 32'h0,
    parameter logic [31:0] WMASK   = 32'h0,
    parameter bit          IS_CTRL = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] q
);
    localparam logic [31:0] FLAG_BITS = IS_CTRL ? 32'h0000_0C00 : 32'h0;
    localparam logic [31:0] CHG_MASK  = WMASK | FLAG_BITS;

    logic [31:0] merged;
    logic [31:0] nxt;

    // Merge new data with the kept bits, then apply the commit rule.
    always_comb begin
        merged = (wdata & WMASK) | (q & ~WMASK);
        nxt    = merged;
        if (IS_CTRL) begin
            nxt[10] = merged[9];
            nxt[11] = 1'b0;
        end
    end

    // Storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST_VAL;
        else if (we) q <= nxt;
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q)); // R2
    AST_RO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((q ^ $past(q)) & ~CHG_MASK) == 32'h0); // R2

    if (IS_CTRL) begin : g_ctrl_chk
        AST_COMMIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (we && wdata[9]) |=> (q[10] && !q[11])); // R3
        AST_UNCOMMIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !wdata[9]) |=> (!q[10] && !q[11])); // R4
    end
endmodule

// File: rtl/cr_decoder.sv
// Module: the programming words of one memory decoder.
// Assumes: we bits are one-hot or zero and already qualified by the top.
module cr_decoder
    import comp_regfile_pkg::*;
#(
    parameter bit DEVICE = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [CR_DEC_WORDS-1:0]       we,
    input  logic [31:0]                   wdata,
    output logic [CR_DEC_WORDS-1:0][31:0] q
);
    // One masked word per decoder slot; the control slot gets the handshake.
    for (genvar k = 0; k < CR_DEC_WORDS; k++) begin : g_word
        cr_word #(
            .RST_VAL (32'h0),
            .WMASK   (dec_word_mask(k, DEVICE)),
            .IS_CTRL (k == CR_CTRL_IDX)
        ) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we[k]),
            .wdata (wdata),
            .q     (q[k])
        );
    end
endmodule

// File: rtl/comp_regfile.sv
// Module: component register bank; decodes the bus, holds headers, RAS and decoder words.
// Assumes: word addressing, little-endian data, one access per cycle.
module comp_regfile
    import comp_regfile_pkg::*;
#(
    parameter comp_type_e CTYPE   = CT_MEM,
    parameter int         NUM_DEC = 4,
    parameter int         ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata
);
    localparam int  CAPS   = caps_of(CTYPE);
    localparam bit  RAS_ON = has_ras(CTYPE);
    localparam bit  DEC_ON = has_dec(CTYPE);
    localparam int  N_RAS  = 6;
    localparam int  RAS_BASE = 8;

    localparam logic [31:0] HDR_MAIN = {8'(CAPS), 4'h1, 4'h1, 16'h0001};
    localparam logic [31:0] HDR_RAS  = RAS_ON ? {12'h020, 4'h1, 16'h0002} : 32'h0;
    localparam logic [31:0] HDR_LINK = {12'h000, 4'h1, 16'h0004};
    localparam logic [31:0] HDR_DEC  = DEC_ON ? {12'h040, 4'h1, 16'h0005} : 32'h0;
    localparam logic [31:0] HDR_XSEC = (CAPS == 5) ? {12'h000, 4'h1, 16'h0006} : 32'h0;
    localparam logic [31:0] HDR_SNP  = (CAPS == 5) ? {12'h000, 4'h1, 16'h0008} : 32'h0;
    localparam logic [31:0] DEC_CAP  = DEC_ON ?
        {22'h0, 1'b1, 1'b1, 4'h1, dec_count_enc(NUM_DEC)} : 32'h0;

    typedef logic [31:0] word_t;
    localparam word_t RAS_RST [N_RAS] = '{32'h0, 32'h1CFFF, 32'h1CFFF, 32'h0, 32'h7F, 32'h200};
    localparam word_t RAS_MSK [N_RAS] = '{32'h1CFFF, 32'h1CFFF, 32'h1CFFF, 32'h7F, 32'h7F, 32'h0};

    logic        wr_ok;
    logic        size_ok;
    logic [31:0] rd_val;
    logic [N_RAS-1:0][31:0] ras_q;
    logic [31:0] gctl_q;
    logic [NUM_DEC-1:0][CR_DEC_WORDS-1:0][31:0] dec_q;

    assign size_ok = (bus_size == 4'd4);
    assign wr_ok   = bus_wr && size_ok;

    // RAS words: present for every type that carries the RAS capability.
    for (genvar i = 0; i < N_RAS; i++) begin : g_ras
        cr_word #(
            .RST_VAL (RAS_ON ? RAS_RST[i] : 32'h0),
            .WMASK   (RAS_ON ? RAS_MSK[i] : 32'h0),
            .IS_CTRL (1'b0)
        ) u_ras (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_ok && (bus_addr == ADDR_W'(RAS_BASE + i))),
            .wdata (bus_wdata),
            .q     (ras_q[i])
        );
    end

    // Decoder global control word.
    cr_word #(
        .RST_VAL (32'h0),
        .WMASK   (DEC_ON ? 32'h3 : 32'h0),
        .IS_CTRL (1'b0)
    ) u_gctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok && (bus_addr == ADDR_W'(17))),
        .wdata (bus_wdata),
        .q     (gctl_q)
    );

    // Decoders exist only when the type carries the decoder capability.
    for (genvar n = 0; n < NUM_DEC; n++) begin : g_dec
        if (DEC_ON) begin : g_on
            logic [CR_DEC_WORDS-1:0] we_vec;
            for (genvar k = 0; k < CR_DEC_WORDS; k++) begin : g_we
                assign we_vec[k] = wr_ok &&
                    (bus_addr == ADDR_W'(CR_DEC_BASE + n * CR_STRIDE + k));
            end
            cr_decoder #(.DEVICE(is_device(CTYPE))) u_dec (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (we_vec),
                .wdata (bus_wdata),
                .q     (dec_q[n])
            );
        end else begin : g_off
            assign dec_q[n] = '0;
        end
    end

    // Read multiplexer over every mapped word; everything else reads zero.
    always_comb begin
        rd_val = 32'h0;
        case (bus_addr)
            ADDR_W'(0):  rd_val = HDR_MAIN;
            ADDR_W'(1):  rd_val = HDR_RAS;
            ADDR_W'(2):  rd_val = HDR_LINK;
            ADDR_W'(3):  rd_val = HDR_DEC;
            ADDR_W'(4):  rd_val = HDR_XSEC;
            ADDR_W'(5):  rd_val = HDR_SNP;
            ADDR_W'(16): rd_val = DEC_CAP;
            ADDR_W'(17): rd_val = gctl_q;
            default: begin
                for (int i = 0; i < N_RAS; i++)
                    if (bus_addr == ADDR_W'(RAS_BASE + i)) rd_val = ras_q[i];
                for (int n = 0; n < NUM_DEC; n++)
                    for (int k = 0; k < CR_DEC_WORDS; k++)
                        if (bus_addr == ADDR_W'(CR_DEC_BASE + n * CR_STRIDE + k))
                            rd_val = dec_q[n][k];
            end
        endcase
    end

    // Registered read port; wide reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= 32'h0;
        else if (bus_rd) bus_rdata <= size_ok ? rd_val : 32'h0;
    end

    AST_WIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !size_ok) |=> (bus_rdata == 32'h0)); // R1
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R11
    AST_GCTL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (gctl_q & ~32'h3) == 32'h0); // R8
endmodule

// File: tb/comp_regfile_tb.sv
// Bench: directed tasks, one per scenario, over a memory device, an upstream port and a root port.
module comp_regfile_tb_top;
    import comp_regfile_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [3:0]  size = 4'd4;
    logic [31:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] rdata_mem, rdata_usp, rdata_rp;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    comp_regfile #(.CTYPE(CT_MEM)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_size(size),
        .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata_mem));
    comp_regfile #(.CTYPE(CT_USP)) dut_usp_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_size(size),
        .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata_usp));
    comp_regfile #(.CTYPE(CT_RP)) dut_rp_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_size(size),
        .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata_rp));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [5:0] a, input logic [31:0] d, input logic [3:0] sz);
        @(negedge clk);
        addr = a; wdata = d; size = sz; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; size = 4'd4;
    endtask

    task automatic bread(input logic [5:0] a, input logic [3:0] sz);
        @(negedge clk);
        addr = a; size = sz; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0; size = 4'd4;
    endtask

    task automatic t_reset;
        bread(6'h09, 4'd4); chk("R6 ue mask reset", rdata_mem, 32'h1CFFF);
        bread(6'h0A, 4'd4); chk("R6 ue sev reset", rdata_mem, 32'h1CFFF);
        bread(6'h08, 4'd4); chk("R6 ue status reset", rdata_mem, 32'h0);
        bread(6'h0C, 4'd4); chk("R7 ce mask reset", rdata_mem, 32'h7F);
        bread(6'h0B, 4'd4); chk("R7 ce status reset", rdata_mem, 32'h0);
        bread(6'h0D, 4'd4); chk("R7 ras ctrl reset", rdata_mem, 32'h200);
        bread(6'h11, 4'd4); chk("R8 global ctrl reset", rdata_mem, 32'h0);
        bread(6'h10, 4'd4); chk("R8 decoder cap", rdata_mem, 32'h312);
        bread(6'h1C, 4'd4); chk("R3 ctrl reset", rdata_mem, 32'h0);
    endtask

    task automatic t_masks;
        bwrite(6'h09, 32'h0, 4'd4);
        bread(6'h09, 4'd4); chk("R6 ue mask cleared", rdata_mem, 32'h0);
        bwrite(6'h09, 32'hFFFF_FFFF, 4'd4);
        bread(6'h09, 4'd4); chk("R6 ue mask masked set", rdata_mem, 32'h1CFFF);
        bwrite(6'h0B, 32'hFFFF_FFFF, 4'd4);
        bread(6'h0B, 4'd4); chk("R7 ce status masked", rdata_mem, 32'h7F);
        bwrite(6'h0D, 32'h0, 4'd4);
        bread(6'h0D, 4'd4); chk("R7 ras ctrl read-only", rdata_mem, 32'h200);
        bwrite(6'h11, 32'hFFFF_FFFF, 4'd4);
        bread(6'h11, 4'd4); chk("R8 global ctrl mask", rdata_mem, 32'h3);
        bwrite(6'h00, 32'h0, 4'd4);
        bread(6'h00, 4'd4); chk("R2 header read-only", rdata_mem, 32'h0311_0001);
    endtask

    task automatic t_decoder_words;
        bwrite(6'h18, 32'hFFFF_FFFF, 4'd4);
        bread(6'h18, 4'd4); chk("R5 base low mask", rdata_mem, 32'hF000_0000);
        bwrite(6'h19, 32'h1234_5678, 4'd4);
        bread(6'h19, 4'd4); chk("R5 base high", rdata_mem, 32'h1234_5678);
        bwrite(6'h1A, 32'h3ABC_DEF0, 4'd4);
        bread(6'h1A, 4'd4); chk("R5 size low mask", rdata_mem, 32'h3000_0000);
        bread(6'h1C, 4'd4); chk("R5 ctrl untouched by base/size", rdata_mem, 32'h0);
        bwrite(6'h1D, 32'hFFFF_FFFF, 4'd4);
        bread(6'h1D, 4'd4);
        chk("R9 device target low", rdata_mem, 32'hF000_0000);
        chk("R9 port target low", rdata_usp, 32'hFFFF_FFFF);
        bwrite(6'h1E, 32'hCAFE_0001, 4'd4);
        bread(6'h1E, 4'd4); chk("R9 target high", rdata_mem, 32'hCAFE_0001);
    endtask

    task automatic t_commit;
        bwrite(6'h2C, 32'h0000_0FFF, 4'd4);
        bread(6'h2C, 4'd4); chk("R3 commit sets committed", rdata_mem, 32'h0000_07FF);
        bwrite(6'h2C, 32'h0000_1000, 4'd4);
        bread(6'h2C, 4'd4); chk("R4 uncommit clears", rdata_mem, 32'h0000_1000);
        bwrite(6'h34, 32'h0000_0200, 4'd4);
        bread(6'h34, 4'd4); chk("R3 commit decoder 3", rdata_mem, 32'h0000_0600);
        bread(6'h24, 4'd4); chk("R3 other decoder untouched", rdata_mem, 32'h0);
    endtask

    task automatic t_wide;
        bwrite(6'h09, 32'h0, 4'd8);
        bread(6'h09, 4'd8); chk("R1 wide read zero", rdata_mem, 32'h0);
        bread(6'h09, 4'd4); chk("R1 wide write dropped", rdata_mem, 32'h1CFFF);
    endtask

    task automatic t_collide;
        bwrite(6'h21, 32'hAAAA_5555, 4'd4);
        @(negedge clk);
        addr = 6'h21; wdata = 32'h0F0F_0F0F; size = 4'd4; wr = 1'b1; rd = 1'b1;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        chk("R11 same-cycle read sees old", rdata_mem, 32'hAAAA_5555);
        @(negedge clk);
        chk("R11 rdata holds without read", rdata_mem, 32'hAAAA_5555);
        bread(6'h21, 4'd4); chk("R11 next read sees new", rdata_mem, 32'h0F0F_0F0F);
        bwrite(6'h2C, 32'h0000_0200, 4'd4);
        @(negedge clk);
        addr = 6'h2C; wdata = 32'h0; wr = 1'b1; rd = 1'b1;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        chk("R11 ctrl collide old value", rdata_mem, 32'h0000_0600);
        bread(6'h2C, 4'd4); chk("R4 ctrl after collide", rdata_mem, 32'h0);
    endtask

    task automatic t_types;
        bread(6'h00, 4'd4);
        chk("R10 memory header", rdata_mem, 32'h0311_0001);
        chk("R10 upstream header", rdata_usp, 32'h0311_0001);
        chk("R10 root port header", rdata_rp, 32'h0511_0001);
        bread(6'h01, 4'd4); chk("R10 ras header", rdata_mem, 32'h0201_0002);
        bread(6'h02, 4'd4); chk("R10 link header", rdata_rp, 32'h0001_0004);
        bread(6'h03, 4'd4);
        chk("R10 decoder header", rdata_mem, 32'h0401_0005);
        chk("R10 root port no decoder header", rdata_rp, 32'h0);
        bread(6'h04, 4'd4);
        chk("R10 root port ext security", rdata_rp, 32'h0001_0006);
        chk("R10 memory no ext security", rdata_mem, 32'h0);
        bread(6'h05, 4'd4); chk("R10 root port snoop", rdata_rp, 32'h0001_0008);
        bread(6'h10, 4'd4); chk("R10 root port no decoder cap", rdata_rp, 32'h0);
        bread(6'h11, 4'd4); chk("R10 root port global ctrl absent", rdata_rp, 32'h0);
        bread(6'h2C, 4'd4); chk("R10 root port decoder absent", rdata_rp, 32'h0);
        bread(6'h3F, 4'd4); chk("R11 unmapped reads zero", rdata_mem, 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_decoder_words();
        t_commit();
        t_wide();
        t_collide();
        t_types();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule